// File: doc/BRIEF.md
# Operating-Mode Command Validator

This block holds the operating mode of a supply-and-interface controller and decides what happens to each decoded serial command. The five modes are Init, Normal, Stop, Sleep and Restart. Every cycle the block may receive one decoded request: a mode change with a target, a watchdog trigger, a watchdog configuration write, a software reset, a register read, or a general register write. It also receives the two wake-source enable registers as plain vectors.

Each request is checked against the current mode. A legal request is carried out: the mode register moves, or a one-cycle effect strobe is sent to the logic that owns the affected function. An illegal request is either dropped or sent to a fallback mode. Either way it raises a sticky failure flag. Only a dedicated clear strobe resets that flag, and if a new failure arrives in the same cycle as the clear, the failure wins.

Two external events end the transient modes. A wake event moves Sleep to Restart, and a restart-done strobe moves Restart to Normal. Software polls the failure flag through the serial status path, which is outside this block.

Top module: `sbc_mode_ctrl`

## Requirements
- R1: While reset is applied and after it is released, mode_o reads Init (code 0), fail_o reads 0, reject_o reads 0, and every effect strobe reads 0. Mode codes are: Init 0, Normal 1, Stop 2, Sleep 3, Restart 4.
- R2: In Init, a mode request (cmd_kind 0) with target Stop (cmd_target 1) or Sleep (cmd_target 2) moves the mode to Normal and sets fail_o.
- R3: In Init and Normal, the remaining requests are accepted without failure, and each raises the strobe for its kind for one cycle. The kinds are: target Normal (cmd_target 0) moves to Normal; watchdog trigger (kind 1) raises wd_trig_o; watchdog configuration write (kind 2) raises wd_cfg_we_o; software reset (kind 3) raises sw_rst_o and moves to Restart; read (kind 4) has no effect; general write (kind 5 to 7) raises wr_ok_o. In Normal, a Sleep request moves to Sleep when at least one wake enable bit is set.
- R4: In Normal, a Sleep request while every bit of both wake enable vectors is 0 moves the mode to Restart and sets fail_o.
- R5: In Normal, a Stop request moves the mode to Stop without failure, even when every wake enable bit is 0.
- R6: In Stop, a Sleep request moves the mode to Restart and sets fail_o.
- R7: In Stop, a watchdog configuration write or a general write sets fail_o. It raises no strobe and leaves the mode in Stop.
- R8: In Stop, the following are accepted without failure: watchdog trigger, target Normal, software reset (which moves to Restart), read, and a repeated Stop request. The repeated Stop request keeps Stop and raises buck_pwm_o for one cycle. At most one effect strobe is high in any cycle.
- R9: fail_o stays set until a cycle with fail_clr high. After that cycle it reads 0, unless a new failure arrives in the same cycle.
- R10: When a failure and fail_clr arrive in the same cycle, fail_o reads 1 afterwards.
- R11: In Sleep and Restart, commands are ignored: there is no strobe, no failure and no mode change. Sleep moves to Restart on wake_evt, and Restart moves to Normal on restart_done.
- R12: In Init, Normal or Stop, a mode request with the reserved target (cmd_target 3) sets fail_o and leaves the mode unchanged.
- R13: Every result appears on the outputs one clock after the command cycle. reject_o pulses in exactly the cycles that follow a failing command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_kind | input | 3 | Command kind code (see R3) |
| cmd_target | input | 2 | Target mode of a mode request: 0 Normal, 1 Stop, 2 Sleep, 3 reserved |
| fail_clr | input | 1 | Clear strobe for the failure flag |
| bus_wake_en | input | BUS_WAKE_W | Bus wake-source enable vector |
| pin_wake_en | input | PIN_WAKE_W | Pin and timer wake-source enable vector |
| wake_evt | input | 1 | Wake event while in Sleep |
| restart_done | input | 1 | Restart sequence has finished |
| mode_o | output | 3 | Current mode code |
| fail_o | output | 1 | Sticky command-failure flag |
| reject_o | output | 1 | One-cycle pulse after a failing command |
| wd_trig_o | output | 1 | Accepted watchdog trigger strobe |
| wd_cfg_we_o | output | 1 | Accepted watchdog configuration write strobe |
| buck_pwm_o | output | 1 | Strobe to restore buck PWM operation |
| sw_rst_o | output | 1 | Accepted software reset strobe |
| wr_ok_o | output | 1 | Accepted general register write strobe |

## Verification
The bound checker watches several rules on every cycle. It checks the redirects out of Init, the fallback to Restart on a Sleep request with no wake source or from Stop, the rejection of configuration writes in Stop, and the reserved target. It also checks that the failure flag holds until cleared, that a failure beats a simultaneous clear, the exits from Restart and Sleep, and that at most one effect strobe is high at a time. Some behaviour can only be shown by the bench's scenarios. These are the reset values, and the full sweep of every start mode against every command kind, every target and both wake conditions. Together they show that an accepted command raises exactly its own strobe, and that an ignored command leaves everything untouched.

// File: rtl/sbc_mode_pkg.sv
package sbc_mode_pkg;

  typedef enum logic [2:0] {
    M_INIT    = 3'd0,
    M_NORMAL  = 3'd1,
    M_STOP    = 3'd2,
    M_SLEEP   = 3'd3,
    M_RESTART = 3'd4
  } mode_e;

  localparam logic [2:0] K_MODE    = 3'd0;
  localparam logic [2:0] K_WD_TRIG = 3'd1;
  localparam logic [2:0] K_WD_CFG  = 3'd2;
  localparam logic [2:0] K_SW_RST  = 3'd3;
  localparam logic [2:0] K_READ    = 3'd4;

  localparam logic [1:0] T_NORMAL  = 2'd0;
  localparam logic [1:0] T_STOP    = 2'd1;
  localparam logic [1:0] T_SLEEP   = 2'd2;

  typedef struct packed {
    logic wd_trig;
    logic wd_cfg;
    logic buck;
    logic sw_rst;
    logic wr;
  } effect_t;

endpackage

// File: rtl/sbc_rst_sync.sv
module sbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sbc_wake_any.sv
module sbc_wake_any #(
  parameter int BUS_W = 8,
  parameter int PIN_W = 8
) (
  input  logic [BUS_W-1:0] bus_en,
  input  logic [PIN_W-1:0] pin_en,
  output logic             any_en
);

  assign any_en = (|bus_en) | (|pin_en);

endmodule

// File: rtl/sbc_cmd_check.sv
module sbc_cmd_check
  import sbc_mode_pkg::*;
(
  input  mode_e       cur_mode,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_kind,
  input  logic [1:0]  cmd_target,
  input  logic        wake_any,
  input  logic        wake_evt,
  input  logic        restart_done,
  output mode_e       nxt_mode,
  output logic        fail_set,
  output effect_t     effect
);

  logic in_stop;
  assign in_stop = (cur_mode == M_STOP);

  always_comb begin
    nxt_mode = cur_mode;
    fail_set = 1'b0;
    effect   = '0;
    case (cur_mode)
      M_SLEEP: begin
        if (wake_evt) nxt_mode = M_RESTART;
      end
      M_RESTART: begin
        if (restart_done) nxt_mode = M_NORMAL;
      end
      default: begin
        if (cmd_valid) begin
          case (cmd_kind)
            K_MODE: begin
              case (cmd_target)
                T_NORMAL: nxt_mode = M_NORMAL;
                T_STOP: begin
                  if (cur_mode == M_INIT) begin
                    nxt_mode = M_NORMAL;
                    fail_set = 1'b1;
                  end else begin
                    nxt_mode    = M_STOP;
                    effect.buck = in_stop;
                  end
                end
                T_SLEEP: begin
                  if (cur_mode == M_INIT) begin
                    nxt_mode = M_NORMAL;
                    fail_set = 1'b1;
                  end else if (in_stop || !wake_any) begin
                    nxt_mode = M_RESTART;
                    fail_set = 1'b1;
                  end else begin
                    nxt_mode = M_SLEEP;
                  end
                end
                default: fail_set = 1'b1;
              endcase
            end
            K_WD_TRIG: effect.wd_trig = 1'b1;
            K_WD_CFG: begin
              if (in_stop) fail_set      = 1'b1;
              else         effect.wd_cfg = 1'b1;
            end
            K_SW_RST: begin
              nxt_mode      = M_RESTART;
              effect.sw_rst = 1'b1;
            end
            K_READ: ;
            default: begin
              if (in_stop) fail_set  = 1'b1;
              else         effect.wr = 1'b1;
            end
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/sbc_fail_flag.sv
module sbc_fail_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);

  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i | (flag_o & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      if (flag_en) flag_o <= flag_d;
      pulse_o <= set_i;
    end
  end

endmodule

// File: rtl/sbc_mode_ctrl.sv
module sbc_mode_ctrl
  import sbc_mode_pkg::*;
#(
  parameter int BUS_WAKE_W  = 8,
  parameter int PIN_WAKE_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_kind,
  input  logic [1:0]            cmd_target,
  input  logic                  fail_clr,
  input  logic [BUS_WAKE_W-1:0] bus_wake_en,
  input  logic [PIN_WAKE_W-1:0] pin_wake_en,
  input  logic                  wake_evt,
  input  logic                  restart_done,
  output logic [2:0]            mode_o,
  output logic                  fail_o,
  output logic                  reject_o,
  output logic                  wd_trig_o,
  output logic                  wd_cfg_we_o,
  output logic                  buck_pwm_o,
  output logic                  sw_rst_o,
  output logic                  wr_ok_o
);

  localparam int EFFECT_W = $bits(effect_t);

  logic    rst_sync_n;
  logic    wake_any;
  mode_e   mode_q;
  mode_e   mode_d;
  logic    mode_en;
  logic    fail_set;
  effect_t effect_d;
  effect_t effect_q;

  sbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sbc_wake_any #(.BUS_W(BUS_WAKE_W), .PIN_W(PIN_WAKE_W)) u_wake_any (
    .bus_en (bus_wake_en),
    .pin_en (pin_wake_en),
    .any_en (wake_any)
  );

  sbc_cmd_check u_check (
    .cur_mode     (mode_q),
    .cmd_valid    (cmd_valid),
    .cmd_kind     (cmd_kind),
    .cmd_target   (cmd_target),
    .wake_any     (wake_any),
    .wake_evt     (wake_evt),
    .restart_done (restart_done),
    .nxt_mode     (mode_d),
    .fail_set     (fail_set),
    .effect       (effect_d)
  );

  sbc_fail_flag u_fail (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (fail_set),
    .clr_i   (fail_clr),
    .flag_o  (fail_o),
    .pulse_o (reject_o)
  );

  assign mode_en = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q   <= M_INIT;
      effect_q <= effect_t'({EFFECT_W{1'b0}});
    end else begin
      if (mode_en) mode_q <= mode_d;
      effect_q <= effect_d;
    end
  end

  assign mode_o      = mode_q;
  assign wd_trig_o   = effect_q.wd_trig;
  assign wd_cfg_we_o = effect_q.wd_cfg;
  assign buck_pwm_o  = effect_q.buck;
  assign sw_rst_o    = effect_q.sw_rst;
  assign wr_ok_o     = effect_q.wr;

endmodule

// File: rtl/sbc_mode_ctrl_chk.sv
module sbc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic [1:0] cmd_target,
  input logic       fail_clr,
  input logic       wake_none,
  input logic       wake_evt,
  input logic       restart_done,
  input logic [2:0] mode_o,
  input logic       fail_o,
  input logic       reject_o,
  input logic       wd_cfg_we_o,
  input logic       wr_ok_o,
  input logic [4:0] strobes
);

  logic mode_req;
  logic awake_mode;
  assign mode_req   = cmd_valid && (cmd_kind == 3'd0);
  assign awake_mode = (mode_o == 3'd0) || (mode_o == 3'd1) || (mode_o == 3'd2);

  p_init_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 && mode_req && (cmd_target == 2'd1 || cmd_target == 2'd2))
    |=> (mode_o == 3'd1 && fail_o));

  p_nowake_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && mode_req && cmd_target == 2'd2 && wake_none)
    |=> (mode_o == 3'd4 && fail_o));

  p_stop_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && mode_req && cmd_target == 2'd1)
    |=> (mode_o == 3'd2 && !reject_o));

  p_stop_to_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && mode_req && cmd_target == 2'd2)
    |=> (mode_o == 3'd4 && fail_o));

  p_stop_cfg_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && cmd_valid && (cmd_kind == 3'd2 || cmd_kind >= 3'd5))
    |=> (mode_o == 3'd2 && !wd_cfg_we_o && !wr_ok_o && fail_o));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !fail_clr) |=> fail_o);

  p_fail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_clr && !(cmd_valid && awake_mode)) |=> !fail_o);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && cmd_valid && cmd_kind == 3'd2 && fail_clr) |=> fail_o);

  p_restart_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && restart_done) |=> (mode_o == 3'd1 && !reject_o));

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && !wake_evt) |=> (mode_o == 3'd3 && !reject_o && strobes == 5'd0));

  p_reserved_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_mode && mode_req && cmd_target == 2'd3)
    |=> (mode_o == $past(mode_o) && fail_o && reject_o));

endmodule

bind sbc_mode_ctrl sbc_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cmd_valid    (cmd_valid),
  .cmd_kind     (cmd_kind),
  .cmd_target   (cmd_target),
  .fail_clr     (fail_clr),
  .wake_none    (~wake_any),
  .wake_evt     (wake_evt),
  .restart_done (restart_done),
  .mode_o       (mode_o),
  .fail_o       (fail_o),
  .reject_o     (reject_o),
  .wd_cfg_we_o  (wd_cfg_we_o),
  .wr_ok_o      (wr_ok_o),
  .strobes      ({wd_trig_o, wd_cfg_we_o, buck_pwm_o, sw_rst_o, wr_ok_o})
);

// File: tb/sbc_mode_ctrl_test.sv
module sbc_mode_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int PW = 4;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_kind;
  logic [1:0]    cmd_target;
  logic          fail_clr;
  logic [BW-1:0] bus_wake_en;
  logic [PW-1:0] pin_wake_en;
  logic          wake_evt;
  logic          restart_done;
  logic [2:0]    mode_o;
  logic          fail_o, reject_o, wd_trig_o, wd_cfg_we_o, buck_pwm_o, sw_rst_o, wr_ok_o;

  int n_checks;
  int n_fails;
  bit done;

  sbc_mode_ctrl #(.BUS_WAKE_W(BW), .PIN_WAKE_W(PW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_target(cmd_target), .fail_clr(fail_clr), .bus_wake_en(bus_wake_en),
    .pin_wake_en(pin_wake_en), .wake_evt(wake_evt), .restart_done(restart_done),
    .mode_o(mode_o), .fail_o(fail_o), .reject_o(reject_o), .wd_trig_o(wd_trig_o),
    .wd_cfg_we_o(wd_cfg_we_o), .buck_pwm_o(buck_pwm_o), .sw_rst_o(sw_rst_o),
    .wr_ok_o(wr_ok_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int strobes();
    return {wd_trig_o, wd_cfg_we_o, buck_pwm_o, sw_rst_o, wr_ok_o};
  endfunction

  // one command cycle; outputs are valid when this returns
  task automatic issue(input logic [2:0] k, input logic [1:0] t, input logic clr);
    cmd_valid = 1'b1; cmd_kind = k; cmd_target = t; fail_clr = clr;
    @(negedge clk);
    cmd_valid = 1'b0; fail_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // bring the design from reset to a start mode with wake sources enabled
  task automatic goto_mode(input int m);
    bus_wake_en = '1; pin_wake_en = '1;
    do_reset();
    case (m)
      1: issue(3'd0, 2'd0, 1'b0);
      2: begin issue(3'd0, 2'd0, 1'b0); issue(3'd0, 2'd1, 1'b0); end
      3: begin issue(3'd0, 2'd0, 1'b0); issue(3'd0, 2'd2, 1'b0); end
      4: begin issue(3'd0, 2'd0, 1'b0); issue(3'd3, 2'd0, 1'b0); end
      default: ;
    endcase
  endtask

  // expected outcome, derived from the requirement list
  task automatic model(input int m, input int k, input int t, input bit wake,
                       output int em, output int ef, output int es, output string req);
    em = m; ef = 0; es = 0; req = "R3";
    if (m == 3 || m == 4) begin
      req = "R11";
    end else if (k == 0) begin
      if (t == 0) begin em = 1; req = (m == 2) ? "R8" : "R3"; end
      else if (t == 3) begin ef = 1; req = "R12"; end
      else if (m == 0) begin em = 1; ef = 1; req = "R2"; end
      else if (t == 1) begin em = 2; if (m == 2) begin es = 5'b00100; req = "R8"; end else req = "R5"; end
      else if (m == 2) begin em = 4; ef = 1; req = "R6"; end
      else if (!wake) begin em = 4; ef = 1; req = "R4"; end
      else begin em = 3; req = "R3"; end
    end else if (k == 1) begin es = 5'b10000; req = (m == 2) ? "R8" : "R3"; end
    else if (k == 2) begin
      if (m == 2) begin ef = 1; req = "R7"; end else es = 5'b01000;
    end else if (k == 3) begin em = 4; es = 5'b00010; req = (m == 2) ? "R8" : "R3"; end
    else if (k == 4) begin req = (m == 2) ? "R8" : "R3"; end
    else begin
      if (m == 2) begin ef = 1; req = "R7"; end else es = 5'b00001;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int em, ef, es;
    string req;
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = '0; cmd_target = '0; fail_clr = 1'b0;
    bus_wake_en = '0; pin_wake_en = '0; wake_evt = 1'b0; restart_done = 1'b0;

    // R1 reset values, during and after reset
    repeat (2) @(negedge clk);
    check("R1", "mode in reset", mode_o, 0);
    check("R1", "fail in reset", fail_o, 0);
    check("R1", "strobes in reset", strobes(), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "mode after reset", mode_o, 0);
    check("R1", "reject after reset", reject_o, 0);

    // sweep: start mode x kind x target x wake condition
    for (int m = 0; m < 5; m++) begin
      for (int k = 0; k < 6; k++) begin
        for (int t = 0; t < 4; t++) begin
          if (k != 0 && t != 0) continue;
          for (int w = 0; w < 2; w++) begin
            goto_mode(m);
            check("R1", "start mode", mode_o, m);
            bus_wake_en = '0;
            pin_wake_en = (w != 0) ? PW'(1 << (t % PW)) : '0;
            model(m, k, t, w != 0, em, ef, es, req);
            issue(3'(k), 2'(t), 1'b0);
            check(req, "mode", mode_o, em);
            check(req, "fail", fail_o, ef);
            check("R13", "reject pulse", reject_o, ef);
            check(req, "strobes", strobes(), es);
            @(negedge clk);
            check("R13", "strobes drop", strobes(), 0);
            check("R13", "reject drop", reject_o, 0);
          end
        end
      end
    end

    // R9 sticky flag and clear, R10 set beats clear
    goto_mode(2);
    issue(3'd2, 2'd0, 1'b0);
    check("R7", "fail after cfg in stop", fail_o, 1);
    repeat (4) @(negedge clk);
    check("R9", "fail holds while idle", fail_o, 1);
    issue(3'd4, 2'd0, 1'b0);
    issue(3'd0, 2'd0, 1'b0);
    check("R9", "fail holds across accepted cmds", fail_o, 1);
    check("R9", "mode normal", mode_o, 1);
    issue(3'd4, 2'd0, 1'b1);
    check("R9", "fail cleared", fail_o, 0);
    issue(3'd0, 2'd1, 1'b0);
    issue(3'd5, 2'd0, 1'b1);
    check("R10", "set wins over clear", fail_o, 1);
    check("R10", "write strobe blocked", wr_ok_o, 0);
    issue(3'd4, 2'd0, 1'b1);
    check("R9", "clear works afterwards", fail_o, 0);
    issue(3'd4, 2'd0, 1'b1);
    check("R9", "clear on clear flag", fail_o, 0);

    // R11 exits from Sleep and Restart
    goto_mode(3);
    repeat (3) @(negedge clk);
    check("R11", "sleep holds", mode_o, 3);
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    check("R11", "wake to restart", mode_o, 4);
    repeat (3) @(negedge clk);
    check("R11", "restart holds", mode_o, 4);
    restart_done = 1'b1; @(negedge clk); restart_done = 1'b0;
    check("R11", "restart to normal", mode_o, 1);
    check("R11", "no failure on exits", fail_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule